// File: doc/BRIEF.md
# Timer Capture Unit with Edge Prescaler

This unit takes a snapshot of a free-running 16-bit timer whenever a qualified event is seen on an asynchronous input pin. The pin first passes through a two-flop synchronizer, and an edge detector then looks at its output. A 4-bit mode field chooses what counts as an event: any falling edge, any rising edge, every fourth rising edge, or every sixteenth rising edge. Each capture copies the whole timer word into a holding register and sets a sticky flag. Software clears that flag with a one-cycle strobe.

The edge prescaler is cleared whenever the mode field selects off or any non-capture code. It is left untouched on a direct move from one prescale ratio to another, so after such a move the first capture can come early. A direct move between capture modes can also raise a spurious capture. Passing through the off code first avoids both effects, because the first cycle after leaving a non-capture code never qualifies an edge.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset, capValue is 0 and capFlag is 0.
- R2: In mode 4'b0101 every rising pin edge causes a capture. A pin level applied before clock edge k shows on capValue and capFlag after clock edge k+2, and not before. The captured word is timerVal in the cycle just before edge k+2. Falling edges do not capture in this mode.
- R3: In mode 4'b0100 every falling pin edge causes a capture, and rising edges do not.
- R4: In mode 4'b0110, starting from a cleared prescaler, captures occur on the 4th rising edge and every 4th one after it.
- R5: In mode 4'b0111, starting from a cleared prescaler, captures occur on the 16th rising edge and every 16th one after it.
- R6: capFlag stays at 1 until flagClr is high at a clock edge with no capture at that edge. Then it reads 0 after that edge.
- R7: If flagClr and a capture fall on the same clock edge, capFlag is 1 afterwards and capValue takes the new word.
- R8: A later capture overwrites capValue even when the flag was never cleared. No overrun indication exists.
- R9: In mode 4'b0000 and in any code whose upper two bits are not 2'b01 (for example 4'b1000), no capture occurs and the prescaler count is cleared.
- R10: A direct change between 4'b0111 and 4'b0110 keeps the prescaler count. A capture occurs on the first rising edge at which the count already reaches the new ratio minus one.
- R11: The first cycle after entering a capture mode from a non-capture code never qualifies an edge. A direct change from 4'b0101 to 4'b0100 while the pin is low produces one capture on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capPin | input | 1 | Asynchronous event pin |
| timerVal | input | 16 | Free-running timer word |
| modeSel | input | 4 | Event mode select |
| flagClr | input | 1 | Flag clear strobe |
| capValue | output | 16 | Captured timer word |
| capFlag | output | 1 | Sticky capture flag |

## Verification
A capture and a software clear of the flag can fall on the same clock edge. The capture must win. The bench sets up this case by raising flagClr in the exact cycle in which a synchronized pin edge produces its load. That cycle lies two clock edges after the pin change. The check then requires capFlag to read 1 and capValue to hold the new timer word. A second case checks that a pin edge and a mode change landing together yield exactly one spurious capture on a direct switch and none when the off code is passed through first.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF   = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_FALL  = 4'b0100;
  localparam logic [MODE_W-1:0] MODE_RISE  = 4'b0101;
  localparam logic [MODE_W-1:0] MODE_DIVA  = 4'b0110;
  localparam logic [MODE_W-1:0] MODE_DIVB  = 4'b0111;

  // strobes handed from control to datapath
  typedef struct packed {
    logic load;
    logic clear;
  } cap_strobe_t;

  function automatic logic isCapMode(input logic [MODE_W-1:0] m);
    return m[MODE_W-1:MODE_W-2] == 2'b01;
  endfunction

  function automatic logic isDivMode(input logic [MODE_W-1:0] m);
    return (m == MODE_DIVA) || (m == MODE_DIVB);
  endfunction
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16,
  localparam int CNT_W      = $clog2(DIV_B)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capPin,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              flagClr,
  output cap_strobe_t       strobes,
  output logic [CNT_W-1:0]  prescCount
);
  localparam logic [CNT_W-1:0] TERM_A = CNT_W'(DIV_A - 1);
  localparam logic [CNT_W-1:0] TERM_B = CNT_W'(DIV_B - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinSync;
  logic                   prevSel;
  logic                   armedQ;
  logic                   curSel;
  logic                   edgeHit;
  logic                   capMode;
  logic                   divMode;
  logic [CNT_W-1:0]       termCnt;
  logic                   reachTerm;
  logic                   doLoad;

  // synchronizer chain, one flop per stage
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else if (s == 0) syncQ[s] <= capPin;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinSync = syncQ[SYNC_STAGES-1];
  assign capMode = isCapMode(modeSel);
  assign divMode = isDivMode(modeSel);

  // polarity follows the mode so that a falling edge looks like a rise
  assign curSel  = (modeSel == MODE_FALL) ? ~pinSync : pinSync;
  assign edgeHit = armedQ && capMode && curSel && !prevSel;

  assign termCnt   = (modeSel == MODE_DIVA) ? TERM_A : TERM_B;
  assign reachTerm = prescCount >= termCnt;

  always_comb begin
    doLoad = 1'b0;
    if (edgeHit) doLoad = divMode ? reachTerm : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSel <= 1'b0;
      armedQ  <= 1'b0;
    end else begin
      prevSel <= curSel;
      armedQ  <= capMode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !capMode) prescCount <= '0;
    else if (divMode && edgeHit) begin
      if (reachTerm) prescCount <= '0;
      else prescCount <= prescCount + 1'b1;
    end
  end

  assign strobes.load  = doLoad;
  assign strobes.clear = flagClr;
endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  cap_strobe_t        strobes,
  input  logic [TIMER_W-1:0] timerVal,
  output logic [TIMER_W-1:0] holdValue,
  output logic               flagQ
);
  always_ff @(posedge clk) begin
    if (!rstN) holdValue <= '0;
    else if (strobes.load) holdValue <= timerVal;
  end

  // capture has priority over the clear strobe
  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= 1'b0;
    else if (strobes.load) flagQ <= 1'b1;
    else if (strobes.clear) flagQ <= 1'b0;
  end
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import cap_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16,
  localparam int CNT_W      = $clog2(DIV_B)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               capPin,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic [MODE_W-1:0]  modeSel,
  input  logic               flagClr,
  output logic [TIMER_W-1:0] capValue,
  output logic               capFlag
);
  cap_strobe_t      strobes;
  logic [CNT_W-1:0] prescCount;

  cap_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .DIV_A(DIV_A),
    .DIV_B(DIV_B)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .capPin(capPin),
    .modeSel(modeSel),
    .flagClr(flagClr),
    .strobes(strobes),
    .prescCount(prescCount)
  );

  cap_datapath #(
    .TIMER_W(TIMER_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .timerVal(timerVal),
    .holdValue(capValue),
    .flagQ(capFlag)
  );
endmodule

// File: rtl/cap_checker.sv
module cap_checker
  import cap_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [MODE_W-1:0]  modeSel,
  input logic               flagClr,
  input logic [TIMER_W-1:0] timerVal,
  input logic [TIMER_W-1:0] capValue,
  input logic               capFlag,
  input cap_strobe_t        strobes,
  input logic [CNT_W-1:0]   prescCount
);
  // R7: a load always leaves the flag set, even with a clear alongside
  assert_load_sets_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> capFlag);

  // R6: flag holds without a clear
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClr) |=> capFlag);

  // R8: the held word takes the timer word of the loading cycle
  assert_load_copies_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> capValue == $past(timerVal));

  // R9: prescaler is empty after any non-capture cycle
  assert_presc_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    !isCapMode(modeSel) |=> prescCount == '0);

  // R9: no load is issued outside capture codes
  assert_no_load_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !isCapMode(modeSel) |-> !strobes.load);

  // R2: the flag only rises after a load
  assert_flag_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capFlag) |-> $past(strobes.load));
endmodule

bind tmr_capture_unit cap_checker #(
  .TIMER_W(TIMER_W),
  .CNT_W(CNT_W)
) chk (
  .clk(clk),
  .rstN(rstN),
  .modeSel(modeSel),
  .flagClr(flagClr),
  .timerVal(timerVal),
  .capValue(capValue),
  .capFlag(capFlag),
  .strobes(strobes),
  .prescCount(prescCount)
);

// File: tb/tb_tmr_capture_unit.sv
`timescale 1ns/1ps
module tb_tmr_capture_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capPin = 1'b0;
  logic [15:0] timerVal = 16'h0;
  logic [3:0]  modeSel = 4'b0000;
  logic        flagClr = 1'b0;
  logic [15:0] capValue;
  logic        capFlag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_capture_unit dut (
    .clk(clk), .rstN(rstN), .capPin(capPin), .timerVal(timerVal),
    .modeSel(modeSel), .flagClr(flagClr), .capValue(capValue), .capFlag(capFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pin change, then three falling clock edges so the result is visible
  task automatic setPin(input logic v);
    @(negedge clk) capPin = v;
    waitN(3);
  endtask

  task automatic setMode(input logic [3:0] m);
    @(negedge clk) modeSel = m;
  endtask

  task automatic clearFlag();
    @(negedge clk) flagClr = 1'b1;
    @(negedge clk) flagClr = 1'b0;
  endtask

  task automatic risePulse();
    setPin(1'b1);
    setPin(1'b0);
  endtask

  // go through off so the prescaler starts empty
  task automatic freshMode(input logic [3:0] m);
    setMode(4'b0000);
    waitN(2);
    setMode(m);
    waitN(2);
    clearFlag();
  endtask

  task automatic testReset();
    check("R1 value", capValue, 0);
    check("R1 flag", capFlag, 0);
  endtask

  task automatic testRising();
    freshMode(4'b0101);
    timerVal = 16'h1234;
    @(negedge clk) capPin = 1'b1;
    waitN(2);
    check("R2 latency flag low", capFlag, 0);
    waitN(1);
    check("R2 flag", capFlag, 1);
    check("R2 value", capValue, 16'h1234);
    clearFlag();
    timerVal = 16'h5555;
    setPin(1'b0);
    check("R2 falling ignored flag", capFlag, 0);
    check("R2 falling ignored value", capValue, 16'h1234);
  endtask

  task automatic testFalling();
    freshMode(4'b0100);
    timerVal = 16'h0A0B;
    setPin(1'b1);
    check("R3 rise ignored", capFlag, 0);
    timerVal = 16'hBEEF;
    setPin(1'b0);
    check("R3 flag", capFlag, 1);
    check("R3 value", capValue, 16'hBEEF);
  endtask

  task automatic testDiv4();
    freshMode(4'b0110);
    for (int i = 1; i <= 8; i++) begin
      timerVal = 16'(16'h4000 + i);
      setPin(1'b1);
      check($sformatf("R4 edge %0d", i), capFlag, (i % 4 == 0) ? 1 : 0);
      if (i % 4 == 0) begin
        check("R4 value", capValue, 16'(16'h4000 + i));
        clearFlag();
      end
      setPin(1'b0);
    end
  endtask

  task automatic testDiv16();
    freshMode(4'b0111);
    for (int i = 1; i <= 16; i++) begin
      timerVal = 16'(16'h1600 + i);
      setPin(1'b1);
      if (i == 15) check("R5 edge 15", capFlag, 0);
      if (i == 16) begin
        check("R5 edge 16", capFlag, 1);
        check("R5 value", capValue, 16'h1610);
      end
      setPin(1'b0);
    end
  endtask

  task automatic testSticky();
    freshMode(4'b0101);
    timerVal = 16'h0777;
    risePulse();
    waitN(10);
    check("R6 sticky", capFlag, 1);
    clearFlag();
    check("R6 cleared", capFlag, 0);
  endtask

  task automatic testCollision();
    freshMode(4'b0101);
    timerVal = 16'h1111;
    risePulse();
    timerVal = 16'h2222;
    @(negedge clk) capPin = 1'b1;
    waitN(1);
    @(negedge clk) flagClr = 1'b1;
    @(negedge clk) flagClr = 1'b0;
    check("R7 flag wins", capFlag, 1);
    check("R7 value", capValue, 16'h2222);
    setPin(1'b0);
  endtask

  task automatic testOverwrite();
    freshMode(4'b0101);
    timerVal = 16'h00A1;
    risePulse();
    timerVal = 16'h00B2;
    risePulse();
    check("R8 overwrite", capValue, 16'h00B2);
    check("R8 flag", capFlag, 1);
  endtask

  task automatic testOff();
    freshMode(4'b0000);
    timerVal = 16'h9999;
    risePulse();
    check("R9 off no flag", capFlag, 0);
    // two edges into the divide-by-4 count, then a non-capture code
    freshMode(4'b0110);
    risePulse();
    risePulse();
    setMode(4'b1000);
    waitN(2);
    risePulse();
    check("R9 non-capture no flag", capFlag, 0);
    check("R9 value kept", capValue, 16'h00B2);
    setMode(4'b0110);
    waitN(2);
    for (int i = 1; i <= 4; i++) begin
      timerVal = 16'(16'h9900 + i);
      setPin(1'b1);
      if (i == 3) check("R9 count cleared", capFlag, 0);
      if (i == 4) check("R9 fourth edge", capFlag, 1);
      setPin(1'b0);
    end
  endtask

  task automatic testSwitch();
    freshMode(4'b0111);
    for (int i = 0; i < 10; i++) risePulse();
    check("R10 no early capture", capFlag, 0);
    setMode(4'b0110);
    waitN(2);
    timerVal = 16'hC0DE;
    setPin(1'b1);
    check("R10 early capture", capFlag, 1);
    check("R10 value", capValue, 16'hC0DE);
    setPin(1'b0);
  endtask

  task automatic testModeEntry();
    freshMode(4'b0101);
    timerVal = 16'h3333;
    waitN(4);
    setMode(4'b0100);
    waitN(1);
    check("R11 spurious on direct switch", capFlag, 1);
    check("R11 spurious value", capValue, 16'h3333);
    setMode(4'b0101);
    waitN(2);
    clearFlag();
    setMode(4'b0000);
    waitN(3);
    setMode(4'b0100);
    waitN(4);
    check("R11 no capture via off", capFlag, 0);
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    testReset();
    testRising();
    testFalling();
    testDiv4();
    testDiv16();
    testSticky();
    testCollision();
    testOverwrite();
    testOff();
    testSwitch();
    testModeEntry();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule